// File: doc/BRIEF.md
# Trap-stress march BIST sequencer

This block is a built-in self-test controller for one on-chip synchronous SRAM macro. It runs a fixed march made of four lines and drives the SRAM port directly: chip select, write enable, read enable, address and write data. Read data comes back one cycle after a read. The test aims at write failures caused by charge trapping in the cell transistors. So between the preset of the whole array and the decisive opposite write, it inserts a programmable idle hold with no accesses. In the write-after-write pattern it also adds a programmable burst of repeated writes and a relax gap at every address.

Software or a test wrapper sets the configuration inputs while the controller is idle and pulses `start`. The controller latches the settings and walks the march. It compares every read against the value that the march expects. It keeps a sticky fail flag together with the first failing address, and always runs to the end. When the last line has finished it gives a one-cycle `done` pulse.

Top module: `trap_stress_bist`

## Requirements
- R1: A `start` pulse seen while idle latches every configuration input and makes `busy` high in the next cycle. `start` and any change of the configuration inputs while busy have no effect on the access sequence.
- R2: The preset line writes the value A (`cfg_polarity` replicated over every data bit) once per cycle to every address, in ascending order from 0, beginning in the first busy cycle.
- R3: After the last preset write, exactly `cfg_hold` cycles follow with `mem_cs`, `mem_we` and `mem_re` all low. A value of 0 leaves no idle cycle.
- R4: With `cfg_pattern` = 0 (isolated write), the stress line visits the addresses in ascending order. At each address it writes the inverse of A in one cycle and reads the same address in the next cycle.
- R5: With `cfg_pattern` = 1 (write-after-write), each address of the ascending stress line first gets a burst of back-to-back writes. The burst length is `cfg_burst`, limited to at least 2 and at most 256.
- R6: The burst data bit for write k (k from 0) follows `cfg_burst_mode`: 0 gives A for even k and the inverse for odd k; 1 gives the inverse for even k and A for odd k; 2 gives all zeros; 3 gives all ones.
- R7: In write-after-write, `cfg_relax` idle cycles follow the burst (0 gives none). Then the final write of the inverse of A and a read of the same address follow in two consecutive cycles.
- R8: The third line runs in descending order. At each address it reads, expecting the inverse of A, and writes A in the next cycle. The fourth line reads every address in ascending order, expecting A.
- R9: Each read is compared with its expected value in the cycle its data returns. The first mismatch sets `fail` and captures `fail_addr`. Both stay unchanged until the next accepted `start` clears them, and the march still completes.
- R10: One idle cycle follows the last read. Then `done` is high for exactly one cycle, with `busy` already low and `fail`/`fail_addr` final.
- R11: `mem_cs` is high exactly when a read or write is issued, `mem_we` and `mem_re` are never high together, and no access is issued while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test (taken only while idle) |
| cfg_pattern | input | 1 | 0 isolated write, 1 write-after-write |
| cfg_polarity | input | 1 | Preset data bit A |
| cfg_burst_mode | input | 2 | Burst data mode (see R6) |
| cfg_hold | input | HOLD_W | Idle hold length in cycles |
| cfg_relax | input | RELAX_W | Relax gap length in cycles |
| cfg_burst | input | BCNT_W | Burst write count, limited to 2..BURST_MAX |
| mem_cs | output | 1 | SRAM chip select |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, valid one cycle after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at test end |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 4, so an eight-word array makes every full march short. It keeps BURST_MAX at 256, so both ends of the burst limit can be reached within a few thousand cycles. It uses HOLD_W = 8 and RELAX_W = 4, so hold and relax values of zero, one and several cycles can all be applied. With the small array the memory model can inject stuck bits at two addresses, which shows that the first failing address in march order is the one kept.

// File: rtl/tsb_pkg.sv
// Shared types for the trap-stress march BIST sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tsb_pkg;

    // Sequencer phases; one state per march element kind
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRESET,
        ST_HOLD,
        ST_BURST,
        ST_RELAX,
        ST_FINAL,
        ST_VERIFY,
        ST_L2_RD,
        ST_L2_WR,
        ST_L3_RD,
        ST_FINISH
    } seq_state_t;

    // Burst data mode codes
    localparam logic [1:0] BM_ALT_A   = 2'd0;
    localparam logic [1:0] BM_ALT_INV = 2'd1;
    localparam logic [1:0] BM_ZEROS   = 2'd2;
    localparam logic [1:0] BM_ONES    = 2'd3;

    // Data bit for one burst write, given mode, polarity and write parity
    function automatic logic burst_bit(input logic [1:0] mode,
                                       input logic pol,
                                       input logic odd);
        case (mode)
            BM_ALT_A:   burst_bit = odd ? ~pol : pol;
            BM_ALT_INV: burst_bit = odd ? pol : ~pol;
            BM_ZEROS:   burst_bit = 1'b0;
            default:    burst_bit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tsb_addr_gen.sv
// Address walker for one march line.
// A load starts the walk at the low or high end and fixes the direction.
// A step moves one address. at_end flags the last address of the line.
// Assumes: load and step are never high in the same cycle.
module tsb_addr_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              desc,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic dir_q;

    // Address register and direction latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            dir_q <= 1'b0;
        end else if (load) begin
            addr  <= desc ? TOP_ADDR : '0;
            dir_q <= desc;
        end else if (step) begin
            addr  <= dir_q ? addr - 1'b1 : addr + 1'b1;
        end
    end

    // Last address of the line in the current direction
    always_comb at_end = dir_q ? (addr == '0) : (addr == TOP_ADDR);

endmodule

// File: rtl/tsb_interval_timer.sv
// Countdown timer for the idle intervals (hold and relax).
// A load sets the count, which then falls by one each cycle to zero.
// Assumes: the caller loads length-1 and leaves the interval when zero is seen.
module tsb_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down, saturating at zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Interval has elapsed
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/tsb_resp_check.sv
// Read response comparator with a sticky first-fail capture.
// A read issued in one cycle returns its data in the next. It is compared there,
// and the result is registered at the end of that cycle.
// Assumes: clear is only raised while no read is outstanding.
module tsb_resp_check #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_expect,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;

    // Track the outstanding read and its expectation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            pend_q <= rd_issue;
            addr_q <= rd_addr;
            exp_q  <= rd_expect;
        end
    end

    // Sticky fail flag and first failing address
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (pend_q && (rdata != exp_q) && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
        end
    end

endmodule

// File: rtl/trap_stress_bist.sv
// Trap-stress march BIST sequencer top.
// March: ascending preset of A, idle hold, ascending stress line (isolated
// write or write-after-write with burst and relax, then a verify read),
// descending read-inverse/write-A line, ascending read-A line.
// Assumes: a synchronous SRAM with one-cycle read latency; configuration is
// only sampled on an accepted start.
module trap_stress_bist #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int HOLD_W    = 24,
    parameter int RELAX_W   = 12,
    parameter int BURST_MIN = 2,
    parameter int BURST_MAX = 256,
    localparam int BCNT_W   = $clog2(BURST_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cfg_pattern,
    input  logic               cfg_polarity,
    input  logic [1:0]         cfg_burst_mode,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [RELAX_W-1:0] cfg_relax,
    input  logic [BCNT_W-1:0]  cfg_burst,
    output logic               mem_cs,
    output logic               mem_we,
    output logic               mem_re,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [ADDR_W-1:0]  fail_addr
);
    import tsb_pkg::*;

    localparam logic [BCNT_W-1:0] B_LO = BCNT_W'(BURST_MIN);
    localparam logic [BCNT_W-1:0] B_HI = BCNT_W'(BURST_MAX);

    seq_state_t          state_q, state_d, stress_entry;
    logic                pat_q, pol_q;
    logic [1:0]          mode_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [RELAX_W-1:0]  relax_q;
    logic [BCNT_W-1:0]   burst_n_q, bidx_q, burst_clamped;
    logic                done_q;

    logic                ag_load, ag_desc, ag_step, at_end;
    logic                hold_load, relax_load, hold_zero, relax_zero;
    logic                bidx_clr, bidx_inc, cfg_take, chk_clear;
    logic                rd_issue;
    logic [DATA_W-1:0]   rd_expect;
    logic [DATA_W-1:0]   word_a, word_inv;

    // Burst count limited to the supported range
    always_comb begin
        if (cfg_burst < B_LO)      burst_clamped = B_LO;
        else if (cfg_burst > B_HI) burst_clamped = B_HI;
        else                       burst_clamped = cfg_burst;
    end

    // Data words for polarity A and its inverse
    always_comb begin
        word_a   = {DATA_W{pol_q}};
        word_inv = {DATA_W{~pol_q}};
    end

    // First state of each stress-line address
    always_comb stress_entry = pat_q ? ST_BURST : ST_FINAL;

    // Next-state and walker control
    always_comb begin
        state_d    = state_q;
        ag_load    = 1'b0;
        ag_desc    = 1'b0;
        ag_step    = 1'b0;
        hold_load  = 1'b0;
        relax_load = 1'b0;
        bidx_clr   = 1'b0;
        bidx_inc   = 1'b0;
        cfg_take   = 1'b0;
        chk_clear  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cfg_take  = 1'b1;
                    chk_clear = 1'b1;
                    ag_load   = 1'b1;
                    state_d   = ST_PRESET;
                end
            end
            ST_PRESET: begin
                if (at_end) begin
                    ag_load  = 1'b1;
                    bidx_clr = 1'b1;
                    if (hold_q != '0) begin
                        hold_load = 1'b1;
                        state_d   = ST_HOLD;
                    end else begin
                        state_d   = stress_entry;
                    end
                end else begin
                    ag_step = 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_zero) state_d = stress_entry;
            end
            ST_BURST: begin
                if (bidx_q == burst_n_q - 1'b1) begin
                    if (relax_q != '0) begin
                        relax_load = 1'b1;
                        state_d    = ST_RELAX;
                    end else begin
                        state_d    = ST_FINAL;
                    end
                end else begin
                    bidx_inc = 1'b1;
                end
            end
            ST_RELAX: begin
                if (relax_zero) state_d = ST_FINAL;
            end
            ST_FINAL: state_d = ST_VERIFY;
            ST_VERIFY: begin
                if (at_end) begin
                    ag_load = 1'b1;
                    ag_desc = 1'b1;
                    state_d = ST_L2_RD;
                end else begin
                    ag_step  = 1'b1;
                    bidx_clr = 1'b1;
                    state_d  = stress_entry;
                end
            end
            ST_L2_RD: state_d = ST_L2_WR;
            ST_L2_WR: begin
                if (at_end) begin
                    ag_load = 1'b1;
                    state_d = ST_L3_RD;
                end else begin
                    ag_step = 1'b1;
                    state_d = ST_L2_RD;
                end
            end
            ST_L3_RD: begin
                if (at_end) state_d = ST_FINISH;
                else        ag_step = 1'b1;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and end-of-test pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FINISH);
        end
    end

    // Configuration latch, taken on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q     <= 1'b0;
            pol_q     <= 1'b0;
            mode_q    <= 2'd0;
            hold_q    <= '0;
            relax_q   <= '0;
            burst_n_q <= B_LO;
        end else if (cfg_take) begin
            pat_q     <= cfg_pattern;
            pol_q     <= cfg_polarity;
            mode_q    <= cfg_burst_mode;
            hold_q    <= cfg_hold;
            relax_q   <= cfg_relax;
            burst_n_q <= burst_clamped;
        end
    end

    // Burst write index within one address
    always_ff @(posedge clk) begin
        if (!rst_n || bidx_clr) bidx_q <= '0;
        else if (bidx_inc)      bidx_q <= bidx_q + 1'b1;
    end

    // SRAM port drive, decoded from the current state
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        rd_expect = '0;
        case (state_q)
            ST_PRESET: begin mem_we = 1'b1; mem_wdata = word_a; end
            ST_BURST: begin
                mem_we    = 1'b1;
                mem_wdata = {DATA_W{burst_bit(mode_q, pol_q, bidx_q[0])}};
            end
            ST_FINAL:  begin mem_we = 1'b1; mem_wdata = word_inv; end
            ST_VERIFY: begin mem_re = 1'b1; rd_expect = word_inv; end
            ST_L2_RD:  begin mem_re = 1'b1; rd_expect = word_inv; end
            ST_L2_WR:  begin mem_we = 1'b1; mem_wdata = word_a; end
            ST_L3_RD:  begin mem_re = 1'b1; rd_expect = word_a; end
            default:   ;
        endcase
        mem_cs   = mem_we | mem_re;
        rd_issue = mem_re;
        busy     = (state_q != ST_IDLE);
        done     = done_q;
    end

    tsb_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ag_load),
        .desc   (ag_desc),
        .step   (ag_step),
        .addr   (mem_addr),
        .at_end (at_end)
    );

    tsb_interval_timer #(.CNT_W(HOLD_W)) hold_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_q - 1'b1),
        .zero     (hold_zero)
    );

    tsb_interval_timer #(.CNT_W(RELAX_W)) relax_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (relax_load),
        .load_val (relax_q - 1'b1),
        .zero     (relax_zero)
    );

    tsb_resp_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) check_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (chk_clear),
        .rd_issue  (rd_issue),
        .rd_addr   (mem_addr),
        .rd_expect (rd_expect),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr)
    );

endmodule

// File: rtl/tsb_chk.sv
// Protocol checker for trap_stress_bist, attached by bind.
// Assumes: observes the top-level ports only.
module tsb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_cs,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr
);
    // R11
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_cs);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> (fail && $stable(fail_addr)));

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind trap_stress_bist tsb_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_cs    (mem_cs),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr)
);

// File: tb/trap_stress_bist_tb_top.sv
// Self-checking bench: a behavioural reference builds the expected port
// sequence of each run in queues and compares it with the design every clock.
module trap_stress_bist_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 4;
    localparam int HOLD_W = 8;
    localparam int RELAX_W = 4;
    localparam int BURST_MAX = 256;
    localparam int BCNT_W = $clog2(BURST_MAX + 1);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int DMASK = (1 << DATA_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_pattern = 1'b0;
    logic cfg_polarity = 1'b0;
    logic [1:0] cfg_burst_mode = 2'd0;
    logic [HOLD_W-1:0] cfg_hold = '0;
    logic [RELAX_W-1:0] cfg_relax = '0;
    logic [BCNT_W-1:0] cfg_burst = '0;
    logic mem_cs, mem_we, mem_re, busy, done, fail;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    logic [DATA_W-1:0] mem [DEPTH];
    bit   [DEPTH-1:0] fault_mask = '0;

    int checks = 0;
    int errors = 0;

    // expected sequence
    bit q_we[$];
    bit q_re[$];
    int q_addr[$];
    int q_wd[$];
    bit q_busy[$];
    bit q_done[$];
    string q_tag[$];
    bit exp_fail;
    int exp_faddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_stress_bist #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_W(HOLD_W),
        .RELAX_W(RELAX_W), .BURST_MAX(BURST_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_pattern(cfg_pattern), .cfg_polarity(cfg_polarity),
        .cfg_burst_mode(cfg_burst_mode), .cfg_hold(cfg_hold),
        .cfg_relax(cfg_relax), .cfg_burst(cfg_burst),
        .mem_cs(mem_cs), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // Behavioural SRAM with one-cycle read latency and stuck-at-1 bit 0 faults
    always @(posedge clk) begin
        if (mem_cs && mem_we)
            mem[mem_addr] <= mem_wdata | {{(DATA_W-1){1'b0}}, fault_mask[mem_addr]};
        if (mem_cs && mem_re)
            mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // reference memory used to predict the first mismatch
    int rmem [DEPTH];

    task automatic push(input bit we, input bit re, input int addr, input int wd,
                        input int rexp, input bit bsy, input bit dn, input string tag);
        q_we.push_back(we); q_re.push_back(re); q_addr.push_back(addr);
        q_wd.push_back(wd); q_busy.push_back(bsy); q_done.push_back(dn);
        q_tag.push_back(tag);
        if (we) rmem[addr] = wd | (fault_mask[addr] ? 1 : 0);
        if (re && !exp_fail && rmem[addr] != rexp) begin
            exp_fail = 1'b1;
            exp_faddr = addr;
        end
    endtask

    task automatic build(input bit pat, input bit pol, input int mode,
                         input int hold, input int relax, input int burst);
        int a_w, i_w, n;
        a_w = pol ? DMASK : 0;
        i_w = pol ? 0 : DMASK;
        n = (burst < 2) ? 2 : ((burst > 256) ? 256 : burst);
        q_we.delete(); q_re.delete(); q_addr.delete(); q_wd.delete();
        q_busy.delete(); q_done.delete(); q_tag.delete();
        exp_fail = 1'b0; exp_faddr = 0;
        for (int a = 0; a < DEPTH; a++) push(1, 0, a, a_w, 0, 1, 0, "R2");
        for (int h = 0; h < hold; h++) push(0, 0, 0, 0, 0, 1, 0, "R3");
        for (int a = 0; a < DEPTH; a++) begin
            if (pat) begin
                for (int k = 0; k < n; k++) begin
                    int b;
                    case (mode)
                        0: b = (k % 2 == 0) ? a_w : i_w;
                        1: b = (k % 2 == 0) ? i_w : a_w;
                        2: b = 0;
                        default: b = DMASK;
                    endcase
                    push(1, 0, a, b, 0, 1, 0, "R5 R6");
                end
                for (int r = 0; r < relax; r++) push(0, 0, 0, 0, 0, 1, 0, "R7");
                push(1, 0, a, i_w, 0, 1, 0, "R7");
                push(0, 1, a, 0, i_w, 1, 0, "R7");
            end else begin
                push(1, 0, a, i_w, 0, 1, 0, "R4");
                push(0, 1, a, 0, i_w, 1, 0, "R4");
            end
        end
        for (int a = DEPTH - 1; a >= 0; a--) begin
            push(0, 1, a, 0, i_w, 1, 0, "R8");
            push(1, 0, a, a_w, 0, 1, 0, "R8");
        end
        for (int a = 0; a < DEPTH; a++) push(0, 1, a, 0, a_w, 1, 0, "R8");
        push(0, 0, 0, 0, 0, 1, 0, "R10");
        push(0, 0, 0, 0, 0, 0, 1, "R10");
        push(0, 0, 0, 0, 0, 0, 0, "R10");
    endtask

    task automatic run(input bit pat, input bit pol, input int mode, input int hold,
                       input int relax, input int burst, input bit poke);
        build(pat, pol, mode, hold, relax, burst);
        @(negedge clk);
        start = 1'b1;
        cfg_pattern = pat; cfg_polarity = pol; cfg_burst_mode = 2'(mode);
        cfg_hold = HOLD_W'(hold); cfg_relax = RELAX_W'(relax); cfg_burst = BCNT_W'(burst);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q_we.size(); i++) begin
            string t;
            t = q_tag[i];
            chk((i == 0) ? "R1" : "R10", "busy", int'(busy), int'(q_busy[i]));
            chk("R10", "done", int'(done), int'(q_done[i]));
            chk("R11", "cs", int'(mem_cs), int'(q_we[i] | q_re[i]));
            chk(t, "we", int'(mem_we), int'(q_we[i]));
            chk(t, "re", int'(mem_re), int'(q_re[i]));
            if (q_we[i] || q_re[i]) chk(t, "addr", int'(mem_addr), q_addr[i]);
            if (q_we[i]) chk(t, "wdata", int'(mem_wdata), q_wd[i]);
            if (q_done[i]) begin
                chk("R9", "fail", int'(fail), int'(exp_fail));
                if (exp_fail) chk("R9", "fail_addr", int'(fail_addr), exp_faddr);
            end
            if (poke && i == 12) begin
                // R1: start and new settings while busy must be ignored
                start = 1'b1;
                cfg_pattern = ~pat; cfg_polarity = ~pol; cfg_hold = '1;
                cfg_burst_mode = 2'(mode + 1);
            end
            if (poke && i == 13) start = 1'b0;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10 R11 R9)
        chk("R10", "busy after reset", int'(busy), 0);
        chk("R10", "done after reset", int'(done), 0);
        chk("R11", "cs after reset", int'(mem_cs), 0);
        chk("R9", "fail after reset", int'(fail), 0);
        run(1'b0, 1'b1, 0, 5, 0, 0, 1'b0);   // R4 isolated, R3 hold of 5
        run(1'b1, 1'b0, 0, 0, 2, 3, 1'b1);   // R5 R6 R7, zero hold, R1 poke
        run(1'b1, 1'b1, 1, 3, 0, 1, 1'b0);   // R5 lower clamp, R7 no relax
        run(1'b1, 1'b0, 2, 1, 1, 300, 1'b0); // R5 upper clamp, R6 zeros
        run(1'b1, 1'b1, 3, 2, 3, 2, 1'b0);   // R6 ones
        fault_mask = 8'b0010_1000;           // R9 stuck bits at 3 and 5
        run(1'b0, 1'b1, 0, 4, 0, 0, 1'b0);
        run(1'b1, 1'b0, 0, 0, 1, 2, 1'b0);
        fault_mask = '0;                     // R9 cleared on next start
        run(1'b0, 1'b0, 0, 1, 0, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule